// File: doc/BRIEF.md
# Pipeline Exception Controller

This block sits beside an in-order pipeline and gathers the exception requests raised by its stages: instruction fetch, decode, execute and memory access. When one or more stages report a fault in the same cycle, it picks the one held by the oldest instruction. It then steers fetch to a fixed handler entry address and kills that instruction and everything behind it in the same cycle, so the faulting instruction commits no result.

On the clock edge that ends the accepting cycle, the controller stores the chosen instruction's address plus four in an exception-PC register and its fault code in a cause register. Both registers keep their contents until the next accepted exception. The handler-entry flush lasts one cycle. Any request raised during that cycle belongs to an instruction that is being discarded, so the block ignores it.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `epc` and `cause` clear to zero, and with `rst_n` released and no request present, `redirect_valid` and `flush` are low.
- R2: Stage indices are 0 fetch, 1 decode, 2 execute, 3 memory. When several stages request at once, the highest index wins.
- R3: After an accepted exception, `epc` holds the winning stage's PC plus 4 from the next clock edge on.
- R4: After an accepted exception, `cause` holds the winning stage's 3-bit code from the next edge on. The codes are 0 overflow, 1 divide by zero, 2 parity error, 3 system call, 4 page fault and 5 bad address.
- R5: In the accepting cycle, `redirect_valid` is high in the same cycle and `redirect_pc` equals 0x40000040.
- R6: In the accepting cycle, `flush[i]` is high for the winning stage and for every lower index, and low for every higher index.
- R7: In cycles with no accepted exception, `epc` and `cause` keep their values.
- R8: In the cycle right after an accepted exception, requests have no effect: `redirect_valid` and `flush` stay low, and `epc` and `cause` stay unchanged.
- R9: A request present two cycles after an accepted exception is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | NUM_STAGES | Per-stage exception request, bit i for stage i |
| stage_pc | input | NUM_STAGES*ADDR_W | Per-stage instruction PC, stage i in slice i |
| stage_cause | input | NUM_STAGES*3 | Per-stage fault code, stage i in slice i |
| epc | output | ADDR_W | Recorded PC+4 of the last accepted fault |
| cause | output | 3 | Recorded code of the last accepted fault |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` this cycle |
| redirect_pc | output | ADDR_W | Handler entry address |
| flush | output | NUM_STAGES | Per-stage kill of the instruction and its write enables |

## Verification
Every cycle, the assertions check four things. The flush vector is always a contiguous run that starts at stage 0. A memory-stage fault always flushes every stage and records its own PC plus 4 and its own code. An accepted exception is never followed by another one in the next cycle. The recorded registers do not move unless an exception is accepted.

Only the bench's scenarios can show the rest: the winner among mixed subsets of requests from the younger stages, the requests ignored in the blocked cycle, acceptance resuming right after that cycle, and the reset values. The bench covers these with a cycle-by-cycle reference model.

// File: rtl/exc_pkg.sv
// Shared definitions for the exception controller.
// Assumes stage index grows with instruction age (0 = fetch, top = memory).
package exc_pkg;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_OVF     = 3'd0,
        CAUSE_DIVZ    = 3'd1,
        CAUSE_PARITY  = 3'd2,
        CAUSE_SYSCALL = 3'd3,
        CAUSE_PGFAULT = 3'd4,
        CAUSE_BADADDR = 3'd5
    } cause_e;
endpackage

// File: rtl/exc_arb.sv
// Priority arbiter: picks the highest-index (oldest) requesting stage.
// Assumes req is stable during the cycle; purely combinational.
module exc_arb #(
    parameter int NS   = 4,
    parameter int IDXW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [NS-1:0]   req,
    output logic            any_req,
    output logic [IDXW-1:0] win_idx
);
    // Scan upward so that the last (oldest) requester overrides younger ones.
    always_comb begin
        any_req = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NS; i++) begin
            if (req[i]) begin
                any_req = 1'b1;
                win_idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/exc_gate.sv
// Acceptance gate: accepts a request unless a handler-entry flush happened
// in the previous cycle. Assumes synchronous active-low reset.
module exc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic any_req,
    output logic accept
);
    logic busy_q;

    // Accept only when not inside the one-cycle flush window.
    always_comb accept = any_req && !busy_q;

    // Remember that a flush was issued this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= accept;
    end

    // R8: two accepts in consecutive cycles must never occur.
    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
endmodule

// File: rtl/exc_flush.sv
// Flush generator: kills the winning stage and every younger stage.
// Assumes stage 0 is youngest; combinational.
module exc_flush #(
    parameter int NS   = 4,
    parameter int IDXW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic            accept,
    input  logic [IDXW-1:0] win_idx,
    output logic [NS-1:0]   flush
);
    for (genvar i = 0; i < NS; i++) begin : g_stage
        if (i == 0) begin : g_young
            // The youngest stage is always behind or at the winner.
            assign flush[i] = accept;
        end else begin : g_old
            // Flush when this stage is not older than the winner.
            assign flush[i] = accept && (IDXW'(i) <= win_idx);
        end
    end
endmodule

// File: rtl/exc_record.sv
// Exception-PC and cause registers: load PC+4 and code on accept, else hold.
// Assumes synchronous active-low reset clearing both to zero.
module exc_record #(
    parameter int AW = 32,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] win_pc,
    input  logic [CW-1:0] win_cause,
    output logic [AW-1:0] epc,
    output logic [CW-1:0] cause
);
    // Capture the fault's return address and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else if (accept) begin
            epc   <= win_pc + AW'(4);
            cause <= win_cause;
        end
    end

    // R7: registers move only when an exception was accepted.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(epc) && $stable(cause)));
endmodule

// File: rtl/exc_ctrl.sv
// Pipeline exception controller top: arbitrates per-stage faults, redirects
// fetch to a fixed handler, flushes the faulting and younger stages, and
// records PC+4 and cause. Assumes higher stage index = older instruction.
module exc_ctrl #(
    parameter int          NUM_STAGES  = 4,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] HANDLER_VEC = 32'h4000_0040
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_STAGES-1:0]            exc_req,
    input  logic [NUM_STAGES*ADDR_W-1:0]     stage_pc,
    input  logic [NUM_STAGES*exc_pkg::CAUSE_W-1:0] stage_cause,
    output logic [ADDR_W-1:0]                epc,
    output logic [exc_pkg::CAUSE_W-1:0]      cause,
    output logic                             redirect_valid,
    output logic [ADDR_W-1:0]                redirect_pc,
    output logic [NUM_STAGES-1:0]            flush
);
    localparam int CW   = exc_pkg::CAUSE_W;
    localparam int IDXW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
    localparam int OLD  = NUM_STAGES - 1;

    logic            any_req;
    logic            accept;
    logic [IDXW-1:0] win_idx;
    logic [ADDR_W-1:0] win_pc;
    logic [CW-1:0]     win_cause;

    exc_arb #(.NS(NUM_STAGES), .IDXW(IDXW)) u_arb (
        .req     (exc_req),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    exc_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (any_req),
        .accept  (accept)
    );

    exc_flush #(.NS(NUM_STAGES), .IDXW(IDXW)) u_flush (
        .accept  (accept),
        .win_idx (win_idx),
        .flush   (flush)
    );

    // Select the winning stage's PC and code.
    always_comb begin
        win_pc    = stage_pc[win_idx*ADDR_W +: ADDR_W];
        win_cause = stage_cause[win_idx*CW +: CW];
    end

    exc_record #(.AW(ADDR_W), .CW(CW)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .win_pc    (win_pc),
        .win_cause (win_cause),
        .epc       (epc),
        .cause     (cause)
    );

    // Drive the fetch redirect for the accepting cycle.
    always_comb begin
        redirect_valid = accept;
        redirect_pc    = ADDR_W'(HANDLER_VEC);
    end

    // R6: flush is a contiguous run starting at stage 0.
    p_flush_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((flush != '0) |-> (flush[0] && ((flush & (flush + NUM_STAGES'(1))) == '0))));

    // R2: an oldest-stage fault that is taken flushes every stage.
    p_oldest_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && exc_req[OLD]) |-> (&flush));

    // R3: an oldest-stage fault records its PC plus 4.
    p_epc_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && exc_req[OLD]) |=>
            (epc == $past(stage_pc[OLD*ADDR_W +: ADDR_W]) + ADDR_W'(4)));

    // R4: an oldest-stage fault records its cause code.
    p_cause_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && exc_req[OLD]) |=>
            (cause == $past(stage_cause[OLD*CW +: CW])));

    // R8: no redirect or flush in the cycle following a redirect.
    p_quiet_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!redirect_valid && (flush == '0)));
endmodule

// File: tb/exc_ctrl_test.sv
// Self-checking bench with a behavioural cycle-by-cycle reference model.
module exc_ctrl_test;
    localparam int NS = 4;
    localparam int AW = 32;
    localparam int CW = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NS-1:0]      exc_req = '0;
    logic [NS*AW-1:0]   stage_pc = '0;
    logic [NS*CW-1:0]   stage_cause = '0;
    logic [AW-1:0]      epc;
    logic [CW-1:0]      cause;
    logic               redirect_valid;
    logic [AW-1:0]      redirect_pc;
    logic [NS-1:0]      flush;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit              m_busy = 0;
    logic [AW-1:0]   m_epc = '0;
    logic [CW-1:0]   m_cause = '0;

    exc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .stage_pc(stage_pc),
        .stage_cause(stage_cause), .epc(epc), .cause(cause),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush(flush)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: check registers, drive inputs, check comb outputs, advance model.
    task automatic step(input logic [NS-1:0] req, input logic [AW-1:0] base,
                        input int cbase, input string tag);
        int win;
        bit acc;
        logic [NS-1:0] ef;
        @(negedge clk);
        chk({tag, " R3/R7"}, "epc", 64'(epc), 64'(m_epc));
        chk({tag, " R4/R7"}, "cause", 64'(cause), 64'(m_cause));
        exc_req = req;
        for (int s = 0; s < NS; s++) begin
            stage_pc[s*AW +: AW]    = base + AW'(s * 4);
            stage_cause[s*CW +: CW] = CW'((cbase + s) % 6);
        end
        #1;
        win = -1;
        for (int s = 0; s < NS; s++) if (req[s]) win = s;
        acc = (win >= 0) && !m_busy;
        ef = '0;
        for (int s = 0; s < NS; s++) if (acc && s <= win) ef[s] = 1'b1;
        chk({tag, " R5/R8"}, "redirect_valid", 64'(redirect_valid), 64'(acc));
        if (acc) chk({tag, " R5"}, "redirect_pc", 64'(redirect_pc), 64'h4000_0040);
        chk({tag, " R6/R2"}, "flush", 64'(flush), 64'(ef));
        @(posedge clk);
        if (acc) begin
            m_epc   = base + AW'(win * 4) + AW'(4);
            m_cause = CW'((cbase + win) % 6);
        end
        m_busy = acc;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "epc", 64'(epc), 64'h0);
        chk("R1", "cause", 64'(cause), 64'h0);
        rst_n = 1'b1;
        #1;
        chk("R1", "redirect_valid", 64'(redirect_valid), 64'h0);
        chk("R1", "flush", 64'(flush), 64'h0);
        // R7: idle cycles hold
        step(4'b0000, 32'h100, 0, "idle");
        // single requests per stage, separated by idle cycles
        step(4'b0001, 32'h1000, 0, "if-only");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b0010, 32'h2000, 1, "id-only");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b0100, 32'h3000, 2, "ex-only");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b1000, 32'h4000, 3, "mem-only");
        step(4'b0000, 32'h0, 0, "idle");
        // R2: simultaneous requests
        step(4'b1001, 32'h5000, 4, "mem+if");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b0110, 32'h6000, 5, "ex+id");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b0011, 32'h7000, 2, "id+if");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b1111, 32'h8000, 1, "all");
        // R8: request in cycle right after accept is ignored
        step(4'b1000, 32'h9000, 3, "blocked");
        // R9: accepted again two cycles after
        step(4'b0100, 32'hA000, 4, "resume");
        step(4'b0100, 32'hB000, 0, "blocked2");
        step(4'b0001, 32'hC000, 5, "resume2");
        // continuous request stream: alternating accept/ignore (R8, R9)
        for (int k = 0; k < 6; k++)
            step(4'b0010 | 4'(k & 1), 32'hD000 + 32'(k * 16), k, "stream");
        step(4'b0000, 32'h0, 0, "idle");
        step(4'b0000, 32'hFFFF_FFF0, 0, "idle");
        // mid-run reset returns to R1 state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_epc = '0; m_cause = '0; m_busy = 0;
        @(negedge clk);
        chk("R1", "epc", 64'(epc), 64'h0);
        chk("R1", "cause", 64'(cause), 64'h0);
        rst_n = 1'b1;
        step(4'b1000, 32'hFFFF_FFF8, 5, "wrap");
        step(4'b0000, 32'h0, 0, "idle");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule